// File: doc/BRIEF.md
# DCC Bit Waveform Generator

This block converts a stream of serial data bits, one at a time, into a DCC track waveform. All timing comes from a single-cycle `tick` enable, normally pulsed once per microsecond from a 1 MHz reference, so every duration is counted in whole ticks. A zero bit has its high time and its total length programmed independently, which permits stretched zeros. A one bit always has equal high and low halves, set by a single half-period value.

Inside, two timers run side by side. The zero timer advances only during zero bits, the one timer only during one bits, and the output is the AND of their two waveforms. At the start of every bit a one-cycle active-low sync pulse restarts both timers. In the zero timer this pulse also restarts the high-time counter, so that it begins together with the total-length counter. Every bit opens with a high phase. The block samples the next bit value and the three duration inputs on the tick that ends the current bit, and it raises one-cycle strobes on the output's rising and falling edges, so that a serializer can advance.

Top module: `dccw_bitgen`

## Requirements
- R1: While `rst_n` is low, `dcc_out`, `rise_stb` and `fall_stb` are 0, and the zero waveform is held low. The first tick after reset starts a bit.
- R2: `dcc_out` changes only on a clock edge at which `tick` is 1. Clock edges without a tick have no effect on the output timing.
- R3: A zero bit drives `dcc_out` high for `zero_high` ticks. It then drives it low until `zero_total` ticks have passed since the bit started.
- R4: A one bit drives `dcc_out` high for `one_half` ticks and then low for `one_half` ticks.
- R5: `bit_in` (0 = zero bit, 1 = one bit) is sampled only on the tick that starts a bit. Changes at any other time have no effect on the bit being sent.
- R6: `zero_total`, `zero_high` and `one_half` are sampled only on the tick that starts a bit. Changes in the middle of a bit have no effect until the next bit.
- R7: A duration input of 0 acts as 1 tick. If `zero_total` is not greater than the effective zero high time, the zero bit lasts that high time plus 1 tick.
- R8: `rise_stb` is 1 for exactly the cycle in which `dcc_out` has just gone from 0 to 1, and `fall_stb` for exactly the cycle in which it has just gone from 1 to 0. The two strobes are never 1 together.
- R9: The output is the AND of a zero waveform and a one waveform. Each timer holds its waveform high while the other kind of bit is being sent, so that runs of one kind of bit do not disturb the timing of the other kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timing enable, one per time unit |
| bit_in | input | 1 | Next bit value, sampled at bit start |
| zero_total | input | W | Total zero-bit length in ticks |
| zero_high | input | W | Zero-bit high time in ticks |
| one_half | input | W | One-bit half period in ticks |
| dcc_out | output | 1 | DCC waveform level |
| rise_stb | output | 1 | One-cycle strobe on the output rising edge (bit start) |
| fall_stb | output | 1 | One-cycle strobe on the output falling edge (mid-bit) |

## Verification
The assertions assume that every input is synchronous to `clk` and that `tick` may follow any pattern, from every cycle down to sparse and irregular. They also assume that reset is released cleanly, between clock edges. The bench drives all inputs on the falling clock edge. It mixes a tick on every cycle with random tick densities, and it changes `bit_in` and the duration inputs freely in the middle of bits. This exercises the sampling rules without ever presenting an input that is not synchronous. Duration values are kept small, including 0 and zero-high values that exceed the zero total, so that many complete bits pass within the run.

// File: rtl/dccw_pkg.sv
package dccw_pkg;
   // phase of the symmetric one-bit timer
   typedef enum logic {
      HALF_HIGH = 1'b0,
      HALF_LOW  = 1'b1
   } half_e;
endpackage

// File: rtl/dccw_zero_gen.sv
module dccw_zero_gen #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          sync_n,
   input  logic [CW-1:0] high_len,
   input  logic [CW-1:0] total_len,
   output logic          wave,
   output logic          fall,
   output logic          done
);
   logic [CW-1:0] tot_cnt, hi_cnt, tot_nxt, hi_nxt;
   logic          hi_done;

   assign tot_nxt = tot_cnt + CW'(1);
   assign hi_nxt  = hi_cnt + CW'(1);
   assign fall    = run && !hi_done && (hi_nxt == high_len);
   assign done    = run && (tot_nxt == total_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tot_cnt <= '0;
         hi_cnt  <= '0;
         hi_done <= 1'b0;
         wave    <= 1'b0;          // forced low until the first bit
      end else if (!sync_n) begin
         tot_cnt <= '0;
         hi_cnt  <= '0;
         hi_done <= 1'b0;
         wave    <= 1'b1;
      end else if (run) begin
         tot_cnt <= tot_nxt;
         if (!hi_done) hi_cnt <= hi_nxt;
         if (fall) begin
            wave    <= 1'b0;
            hi_done <= 1'b1;
         end
      end
   end

   AST_ZERO_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> wave);                                                    // R3
   AST_ZERO_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_n && !run) |=> ($stable(tot_cnt) && $stable(wave)));         // R9
endmodule

// File: rtl/dccw_one_gen.sv
module dccw_one_gen
   import dccw_pkg::*;
#(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          sync_n,
   input  logic [CW-1:0] half_len,
   output logic          wave,
   output logic          fall,
   output logic          done
);
   logic [CW-1:0] cnt, cnt_nxt;
   half_e         phase;
   logic          half_end;

   assign cnt_nxt  = cnt + CW'(1);
   assign half_end = run && (cnt_nxt == half_len);
   assign fall     = half_end && (phase == HALF_HIGH);
   assign done     = half_end && (phase == HALF_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= HALF_HIGH;
         wave  <= 1'b1;
      end else if (!sync_n) begin
         cnt   <= '0;
         phase <= HALF_HIGH;
         wave  <= 1'b1;
      end else if (run) begin
         if (half_end) begin
            cnt   <= '0;
            phase <= HALF_LOW;
            wave  <= 1'b0;
         end else begin
            cnt <= cnt_nxt;
         end
      end
   end

   AST_ONE_PHASE_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == HALF_HIGH) |-> wave);                                    // R4
   AST_ONE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_n && !run) |=> ($stable(cnt) && $stable(wave)));             // R9
endmodule

// File: rtl/dccw_bitgen.sv
module dccw_bitgen #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         bit_in,
   input  logic [W-1:0] zero_total,
   input  logic [W-1:0] zero_high,
   input  logic [W-1:0] one_half,
   output logic         dcc_out,
   output logic         rise_stb,
   output logic         fall_stb
);
   localparam int CW = W + 1;

   generate
      if (W < 2 || W > 24) begin : g_bad_width
         $error("dccw_bitgen: W must lie in 2..24");
      end
   endgenerate

   logic          start, cur_bit, boundary, sync_n;
   logic          z_run, o_run, z_wave, o_wave, z_fall, o_fall, z_done, o_done;
   logic [CW-1:0] z_hi_in, z_tot_in, o_half_in;
   logic [CW-1:0] z_hi_eff, z_tot_eff, o_half_eff;
   logic [CW-1:0] z_hi_q, z_tot_q, o_half_q;

   // effective durations: 0 -> 1, zero total at least high + 1
   assign z_hi_in    = {1'b0, zero_high};
   assign z_tot_in   = {1'b0, zero_total};
   assign o_half_in  = {1'b0, one_half};
   assign z_hi_eff   = (zero_high == '0) ? CW'(1) : z_hi_in;
   assign z_tot_eff  = (z_tot_in > z_hi_eff) ? z_tot_in : (z_hi_eff + CW'(1));
   assign o_half_eff = (one_half == '0) ? CW'(1) : o_half_in;

   assign boundary = tick && (start || (cur_bit ? o_done : z_done));
   assign sync_n   = !boundary;
   assign z_run    = tick && !start && !cur_bit;
   assign o_run    = tick && !start && cur_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start    <= 1'b1;
         cur_bit  <= 1'b0;
         z_hi_q   <= CW'(1);
         z_tot_q  <= CW'(2);
         o_half_q <= CW'(1);
      end else if (boundary) begin
         start    <= 1'b0;
         cur_bit  <= bit_in;
         z_hi_q   <= z_hi_eff;
         z_tot_q  <= z_tot_eff;
         o_half_q <= o_half_eff;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         rise_stb <= boundary;
         fall_stb <= z_fall | o_fall;
      end
   end

   dccw_zero_gen #(.CW(CW)) u_zero (
      .clk(clk), .rst_n(rst_n), .run(z_run), .sync_n(sync_n),
      .high_len(z_hi_q), .total_len(z_tot_q),
      .wave(z_wave), .fall(z_fall), .done(z_done)
   );

   dccw_one_gen #(.CW(CW)) u_one (
      .clk(clk), .rst_n(rst_n), .run(o_run), .sync_n(sync_n),
      .half_len(o_half_q),
      .wave(o_wave), .fall(o_fall), .done(o_done)
   );

   assign dcc_out = z_wave & o_wave;

   AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (dcc_out && !$past(dcc_out)));                        // R8
   AST_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!dcc_out && $past(dcc_out)));                        // R8
   AST_EDGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (dcc_out != $past(dcc_out)) |-> (rise_stb || fall_stb));           // R8
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));                                          // R8
   AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(dcc_out));                                       // R2
   AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ($stable(z_hi_q) && $stable(z_tot_q) && $stable(o_half_q) && $stable(cur_bit))); // R6
   AST_ZERO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_bit && !start) |-> z_wave);                                   // R9
   AST_ONE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_bit |-> o_wave);                                              // R9
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !dcc_out);                                               // R1
endmodule

// File: tb/dccw_bitgen_test.sv
module dccw_bitgen_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b0;
   logic         bit_in = 1'b0;
   logic [W-1:0] zero_total = '0, zero_high = '0, one_half = '0;
   logic         dcc_out, rise_stb, fall_stb;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dccw_bitgen #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bit_in(bit_in),
      .zero_total(zero_total), .zero_high(zero_high), .one_half(one_half),
      .dcc_out(dcc_out), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   // reference model, built from the requirements
   bit m_start, m_bit, m_out, m_rise, m_fall;
   int m_el, m_h, m_t;

   function automatic int lift1(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int zero_len(input int hi, input int tot);
      return (tot > hi) ? tot : hi + 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_start = 1'b1; m_out = 1'b0; m_rise = 1'b0; m_fall = 1'b0;
         m_el = 0; m_h = 1; m_t = 2; m_bit = 1'b0;
      end else begin
         m_rise = 1'b0;
         m_fall = 1'b0;
         if (tick) begin
            if (m_start || (m_el + 1 == m_t)) begin
               m_start = 1'b0;
               m_bit   = bit_in;
               if (bit_in) begin
                  m_h = lift1(int'(one_half));
                  m_t = 2 * m_h;
               end else begin
                  m_h = lift1(int'(zero_high));
                  m_t = zero_len(m_h, int'(zero_total));
               end
               m_el = 0; m_out = 1'b1; m_rise = 1'b1;
            end else begin
               m_el++;
               if (m_el == m_h) begin
                  m_out = 1'b0;
                  m_fall = 1'b1;
               end
            end
         end
      end
   end

   task automatic step(input string tag);
      @(negedge clk);
      n_chk++;
      if (dcc_out !== m_out || rise_stb !== m_rise || fall_stb !== m_fall) begin
         n_fail++;
         $display("FAIL %s: dcc/rise/fall actual %b%b%b expected %b%b%b at %0t",
                  tag, dcc_out, rise_stb, fall_stb, m_out, m_rise, m_fall, $time);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd5150));
      // R1: reset state
      zero_high = 8'd2; zero_total = 8'd5; one_half = 8'd3;
      for (int i = 0; i < 4; i++) step("R1 reset");
      rst_n = 1'b1;
      step("R1 idle after reset");
      step("R1 idle after reset");
      // R1 / R3: first tick starts a zero bit; tick every cycle
      tick = 1'b1;
      for (int i = 0; i < 40; i++) step("R1 R3 zero bits");
      // R4 / R9: one bits, then back to zeros
      bit_in = 1'b1;
      for (int i = 0; i < 40; i++) step("R4 R9 one bits");
      bit_in = 1'b0;
      for (int i = 0; i < 20; i++) step("R9 return to zero");
      // R7: zero durations and inverted zero timing
      zero_high = 8'd0; zero_total = 8'd0; one_half = 8'd0;
      for (int i = 0; i < 12; i++) step("R7 zero values, zero bits");
      bit_in = 1'b1;
      for (int i = 0; i < 12; i++) step("R7 zero half, one bits");
      bit_in = 1'b0; zero_high = 8'd6; zero_total = 8'd3;
      for (int i = 0; i < 30; i++) step("R7 high beyond total");
      // R3: long stretched zero
      zero_high = 8'd20; zero_total = 8'd90;
      for (int i = 0; i < 200; i++) step("R3 stretched zero");
      // R2: sparse ticks
      zero_high = 8'd3; zero_total = 8'd7; one_half = 8'd4;
      for (int i = 0; i < 600; i++) begin
         tick = ($urandom_range(0, 4) == 0);
         if (i % 97 == 0) bit_in = ~bit_in;
         step("R2 sparse ticks");
      end
      // R5 R6 R8 R9: random bits and settings changing mid-bit
      for (int i = 0; i < 20000; i++) begin
         tick = ($urandom_range(0, 2) != 0);
         if ($urandom_range(0, 3) == 0) bit_in = $urandom_range(0, 1) == 1;
         if ($urandom_range(0, 7) == 0) zero_high  = W'($urandom_range(0, 7));
         if ($urandom_range(0, 7) == 0) zero_total = W'($urandom_range(0, 12));
         if ($urandom_range(0, 7) == 0) one_half   = W'($urandom_range(0, 6));
         step("R5 R6 R8 R9 random");
      end
      // R1: reset mid-bit
      @(negedge clk);
      rst_n = 1'b0;
      tick = 1'b0;
      step("R1 mid-run reset");
      finish_run();
   end
endmodule